// File: doc/BRIEF.md
# Nine-bit multiprocessor serial receiver

This block receives asynchronous serial characters that carry nine data bits, as used by the listening nodes of a shared half-duplex bus. Each character begins with a low start bit, continues with nine data bits sent least significant bit first, and ends with one high stop bit. There is no parity bit. The ninth bit tags the character: 1 for an address, 0 for data. The line is oversampled at sixteen times the bit rate. The sampling tick is derived from the system clock by a programmable divisor.

A completed character goes into a single holding register. It leaves the block through a valid/ready handshake as an 8-bit payload, the address/data tag, and two error flags. A stop bit sampled low raises the framing error flag. A character that completes while the register is still occupied raises the overrun flag. While the filter input is high, data characters are dropped without a trace and only address characters reach the holding register. Software keeps the filter on while it waits to be addressed, and turns it off once its own address arrives.

The control state machine has five states:
- S_IDLE waits for a low line on a tick.
- S_START checks the start bit at its midpoint. On a low sample it takes the *confirm* transition to S_DATA. On a high sample it takes the *glitch* transition back to S_IDLE.
- S_DATA samples nine bits and then takes the *last-bit* transition to S_STOP.
- S_STOP samples the stop bit. On a high sample it takes the *clean end* transition to S_IDLE. On a low sample it takes the *framing fault* transition to S_RECOVER.
- S_RECOVER waits for the line to return high, then takes the *line released* transition to S_IDLE.

Top module: `nbr_uart_rx9`

## Requirements
- R1: A frame of one low start bit, nine data bits (least significant first) and one high stop bit is delivered with data bits 0..7 on `rd_data` and data bit 8 on `rd_is_addr`.
- R2: `rd_is_addr` is 1 for a character whose ninth bit is 1 (address) and 0 for a character whose ninth bit is 0 (data).
- R3: One oversampling tick occurs every `baud_div`+1 clocks, and a bit lasts 16 ticks. For example, a divisor of 103 at 16 MHz gives 9600 bit/s. Frames sent at the rate set by the divisor are received correctly for different divisor values.
- R4: A low pulse on the idle line that is high again at the start bit's midpoint (tick 8 of 16) is ignored: nothing is delivered, and the next proper frame is received intact.
- R5: A character whose stop bit samples 0 is delivered with `rd_frame_err` = 1. The receiver then waits for the line to go high before it looks for a new start bit.
- R6: A character that completes while `rd_valid` is 1 and no read takes place is lost. The held character is kept unchanged and its `rd_overrun` flag is set.
- R7: While `filter_en` = 1, characters with ninth bit 0 are discarded without raising `rd_valid`, and characters with ninth bit 1 are delivered.
- R8: `rd_valid` and the held fields stay stable until a read (`rd_valid` and `rd_ready` both 1 on a clock edge). That read clears `rd_valid`, `rd_frame_err` and `rd_overrun`.
- R9: After reset, `rd_valid`, `rd_frame_err` and `rd_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | 16 | Tick divisor: one tick every baud_div+1 clocks |
| rx_in | input | 1 | Serial line, idle high, asynchronous |
| filter_en | input | 1 | Drop data characters (ninth bit 0) while high |
| rd_ready | input | 1 | Consumer accepts the held character |
| rd_valid | output | 1 | Holding register contains a character |
| rd_data | output | 8 | Received payload |
| rd_is_addr | output | 1 | Ninth bit of the held character |
| rd_frame_err | output | 1 | Stop bit of the held character sampled low |
| rd_overrun | output | 1 | A later character was lost while this one was held |

## Verification
The main path is exercised with payloads of alternating, all-ones, all-zeros and single-high-bit patterns, each with both ninth-bit values. These patterns expose bit-order reversal, off-by-one sampling and a swapped tag. Repeating frames with the filter on and off shows that the filter acts on the tag alone and not on the payload. A frame with a low stop bit, followed by a clean frame, checks that the framing flag is tied to one character and that recovery works. Short start glitches, two back-to-back unread frames and a second divisor value separate correct midpoint sampling, overrun retention and rate scaling.

// File: rtl/nbr_rx9_pkg.sv
package nbr_rx9_pkg;
    localparam int PAYLOAD_W = 8;
    localparam int FRAME_BITS = PAYLOAD_W + 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_RECOVER
    } rx_state_t;

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic                 ninth;
        logic                 ferr;
    } rx_char_t;
endpackage

// File: rtl/nbr_tick_gen.sv
module nbr_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= div) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/nbr_frame_fsm.sv
module nbr_frame_fsm
    import nbr_rx9_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rx_raw,
    output logic     done,
    output rx_char_t char_out
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int HALF   = OVS / 2;
    localparam int BCNT_W = $clog2(FRAME_BITS + 1);

    rx_state_t            state_q, state_d;
    logic [CNT_W-1:0]     tcnt_q, tcnt_d;
    logic [BCNT_W-1:0]    bcnt_q, bcnt_d;
    logic [FRAME_BITS-1:0] shift_q, shift_d;
    logic [1:0]           sync_q;
    logic                 rx_s;
    logic                 done_d, ferr_d;

    assign rx_s = sync_q[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shift_q <= '0;
            sync_q  <= 2'b11;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
            bcnt_q  <= bcnt_d;
            shift_q <= shift_d;
            sync_q  <= {sync_q[0], rx_raw};
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        bcnt_d  = bcnt_q;
        shift_d = shift_q;
        done_d  = 1'b0;
        ferr_d  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                tcnt_d = '0;
                bcnt_d = '0;
                if (tick && !rx_s) state_d = S_START;
            end
            S_START: begin
                if (tick) begin
                    if (tcnt_q == CNT_W'(HALF - 1)) begin
                        tcnt_d  = '0;
                        state_d = rx_s ? S_IDLE : S_DATA;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (tcnt_q == CNT_W'(OVS - 1)) begin
                        tcnt_d  = '0;
                        shift_d = {rx_s, shift_q[FRAME_BITS-1:1]};
                        bcnt_d  = bcnt_q + 1'b1;
                        if (bcnt_q == BCNT_W'(FRAME_BITS - 1)) state_d = S_STOP;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (tcnt_q == CNT_W'(OVS - 1)) begin
                        tcnt_d  = '0;
                        done_d  = 1'b1;
                        ferr_d  = !rx_s;
                        state_d = rx_s ? S_IDLE : S_RECOVER;
                    end else begin
                        tcnt_d = tcnt_q + 1'b1;
                    end
                end
            end
            S_RECOVER: begin
                if (rx_s) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            char_out <= '0;
        end else begin
            done <= done_d;
            if (done_d) begin
                char_out.payload <= shift_q[PAYLOAD_W-1:0];
                char_out.ninth   <= shift_q[FRAME_BITS-1];
                char_out.ferr    <= ferr_d;
            end
        end
    end
endmodule

// File: rtl/nbr_hold_reg.sv
module nbr_hold_reg
    import nbr_rx9_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  rx_char_t             char_in,
    input  logic                 filter_en,
    input  logic                 rd_ready,
    output logic                 rd_valid,
    output logic [PAYLOAD_W-1:0] rd_data,
    output logic                 rd_is_addr,
    output logic                 rd_frame_err,
    output logic                 rd_overrun
);
    logic accept, take;

    assign accept = done && (!filter_en || char_in.ninth);
    assign take   = rd_valid && rd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            rd_is_addr   <= 1'b0;
            rd_frame_err <= 1'b0;
            rd_overrun   <= 1'b0;
        end else if (accept && rd_valid && !take) begin
            rd_overrun <= 1'b1;
        end else if (accept) begin
            rd_valid     <= 1'b1;
            rd_data      <= char_in.payload;
            rd_is_addr   <= char_in.ninth;
            rd_frame_err <= char_in.ferr;
            rd_overrun   <= 1'b0;
        end else if (take) begin
            rd_valid     <= 1'b0;
            rd_frame_err <= 1'b0;
            rd_overrun   <= 1'b0;
        end
    end
endmodule

// File: rtl/nbr_uart_rx9.sv
module nbr_uart_rx9
    import nbr_rx9_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             rx_in,
    input  logic             filter_en,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rd_is_addr,
    output logic             rd_frame_err,
    output logic             rd_overrun
);
    logic     tick;
    logic     fsm_done;
    rx_char_t fsm_char;

    nbr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .div  (baud_div),
        .tick (tick)
    );

    nbr_frame_fsm #(.OVS(OVS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_raw  (rx_in),
        .done    (fsm_done),
        .char_out(fsm_char)
    );

    nbr_hold_reg u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (fsm_done),
        .char_in     (fsm_char),
        .filter_en   (filter_en),
        .rd_ready    (rd_ready),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .rd_is_addr  (rd_is_addr),
        .rd_frame_err(rd_frame_err),
        .rd_overrun  (rd_overrun)
    );
endmodule

// File: rtl/nbr_uart_rx9_chk.sv
module nbr_uart_rx9_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       filter_en,
    input logic       rd_ready,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       rd_is_addr,
    input logic       rd_frame_err,
    input logic       rd_overrun,
    input logic       fsm_done,
    input logic       fsm_ninth
);
    p_hold_until_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_is_addr)));

    p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_frame_err && !rd_overrun));

    p_filter_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_done && filter_en && !fsm_ninth && !rd_valid) |=> !rd_valid);

    p_overrun_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_done && (!filter_en || fsm_ninth) && rd_valid && !rd_ready)
        |=> (rd_valid && rd_overrun && $stable(rd_data)));

    p_addr_delivery_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_done && fsm_ninth && !rd_valid) |=> (rd_valid && rd_is_addr));
endmodule

bind nbr_uart_rx9 nbr_uart_rx9_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .filter_en   (filter_en),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_is_addr  (rd_is_addr),
    .rd_frame_err(rd_frame_err),
    .rd_overrun  (rd_overrun),
    .fsm_done    (fsm_done),
    .fsm_ninth   (fsm_char.ninth)
);

// File: tb/nbr_uart_rx9_tb.sv
`timescale 1ns/1ps
module nbr_uart_rx9_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd3;
    logic        rx_in = 1'b1;
    logic        filter_en = 1'b0;
    logic        rd_ready = 1'b0;
    logic        rd_valid, rd_is_addr, rd_frame_err, rd_overrun;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nbr_uart_rx9 u_dut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_in(rx_in),
        .filter_en(filter_en), .rd_ready(rd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_is_addr(rd_is_addr),
        .rd_frame_err(rd_frame_err), .rd_overrun(rd_overrun)
    );

    // {filter, ninth, data[7:0], stop, expect_delivered}
    localparam int NVEC = 8;
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'hA5, 1'b1, 1'b1},   // R1 data frame
        {1'b0, 1'b1, 8'h3C, 1'b1, 1'b1},   // R2 address frame
        {1'b0, 1'b0, 8'hFF, 1'b1, 1'b1},   // R1 all ones
        {1'b0, 1'b0, 8'h7F, 1'b0, 1'b1},   // R5 low stop bit
        {1'b1, 1'b0, 8'h55, 1'b1, 1'b0},   // R7 dropped data
        {1'b1, 1'b1, 8'h09, 1'b1, 1'b1},   // R7 address passes
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1},   // R2 zero payload address
        {1'b0, 1'b0, 8'h80, 1'b1, 1'b1}    // R8 flags clean after FE
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic ninth, input logic stop);
        int bitclk;
        logic [10:0] bits;
        bitclk = 16 * (int'(baud_div) + 1);
        bits = {stop, ninth, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx_in = bits[i];
            repeat (bitclk - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * bitclk) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        check("R9 valid", rd_valid, 0);
        check("R9 ferr", rd_frame_err, 0);
        check("R9 ovr", rd_overrun, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            logic f, n, s, e;
            logic [7:0] d;
            {f, n, d, s, e} = VEC[v];
            filter_en = f;
            send_frame(d, n, s);
            check($sformatf("R7 vec%0d delivered", v), rd_valid, e);
            if (e) begin
                check($sformatf("R1 vec%0d data", v), rd_data, d);
                check($sformatf("R2 vec%0d tag", v), rd_is_addr, n);
                check($sformatf("R5 vec%0d ferr", v), rd_frame_err, !s);
                check($sformatf("R6 vec%0d ovr", v), rd_overrun, 0);
                do_read();
                check($sformatf("R8 vec%0d cleared", v), {rd_valid, rd_frame_err, rd_overrun}, 0);
            end
        end
        filter_en = 1'b0;

        // R4 short start glitch
        @(negedge clk);
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (640) @(negedge clk);
        check("R4 glitch ignored", rd_valid, 0);
        send_frame(8'hC3, 1'b1, 1'b1);
        check("R4 next frame data", rd_data, 8'hC3);
        check("R4 next frame valid", rd_valid, 1);
        // R8 stays until read
        repeat (50) @(negedge clk);
        check("R8 hold valid", rd_valid, 1);
        check("R8 hold data", rd_data, 8'hC3);
        do_read();

        // R6 overrun
        send_frame(8'h11, 1'b0, 1'b1);
        send_frame(8'h22, 1'b1, 1'b1);
        check("R6 ovr flag", rd_overrun, 1);
        check("R6 kept data", rd_data, 8'h11);
        check("R6 kept tag", rd_is_addr, 0);
        do_read();
        check("R8 ovr cleared", {rd_valid, rd_overrun}, 0);
        send_frame(8'h33, 1'b0, 1'b1);
        check("R6 fresh data", rd_data, 8'h33);
        check("R6 fresh ovr", rd_overrun, 0);
        do_read();

        // R3 second divisor
        baud_div = 16'd7;
        repeat (40) @(negedge clk);
        send_frame(8'h6D, 1'b1, 1'b1);
        check("R3 div7 data", rd_data, 8'h6D);
        check("R3 div7 tag", rd_is_addr, 1);
        do_read();
        check("R3 divisor 16MHz/9600", 32'((16000000 / (16 * 9600)) - 1), 103);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule